// File: doc/BRIEF.md
# Flash Endurance Bit-Error Checker

This block sits beside the controller of a flash endurance rig. The rig runs the same loop on one block again and again: erase, program every page with pseudo-random data, then read every page back. The checker supplies the program data and checks the read-back data. It produces one byte of pattern per accepted write beat. On read-back it regenerates the same bytes, compares each returned byte bit by bit, and keeps separate counts for the two error directions.

A strobe on `cycle_start` marks the erase at the start of each loop. It also loads the pattern seed for that loop. A strobe on `page_start` marks each page boundary during read-back. Pages are numbered from 1 after each `cycle_start`, and odd and even pages are counted apart. When `WINDOW` loops have completed, the next `cycle_start` closes the window. At that point the block presents the four totals, pulses `win_valid` for one cycle, and restarts its accumulators at zero.

Both data ports use valid/ready. The write port (`wr_valid`/`wr_ready`/`wr_data`) is driven by the block. It moves one pattern byte when both signals are high on a rising edge. While `wr_ready` is low the byte is held unchanged. The read port (`rd_valid`/`rd_ready`/`rd_data`) accepts one byte when both signals are high on a rising edge. Beats with `rd_valid` low are ignored. The block applies back-pressure on both ports only before the first `cycle_start` and during any cycle in which `cycle_start` is high.

Top module: `flash_endurance_checker`

## Requirements
- R1: After reset, `win_valid` is low, all four window counts are zero, and both `wr_valid` and `rd_ready` are low.
- R2: The pattern comes from a 31-bit shift register state s. A `cycle_start` loads s with `cycle_seed`, or with 1 when the seed is zero. One step computes f = s[30] xor s[27] and then sets s = {s[29:0], f}. Each accepted write beat takes 8 steps, and bit i of the byte is the f of step i (bit 0 first). The byte holds steady while it is offered and not accepted.
- R3: Read-back uses its own copy of the same sequence, loaded by the same `cycle_start` and advanced only by accepted read beats. Beats with `rd_valid` low change nothing.
- R4: A plus error is an expected-0 bit read as 1. Each accepted beat adds its number of plus errors to the plus count of the current page parity.
- R5: A minus error is an expected-1 bit read as 0. These are counted in the minus count of the current page parity.
- R6: Page parity is cleared by `cycle_start` and toggled by each `page_start`, so the first page is odd. Beats use the parity in force at the start of their cycle.
- R7: On the `WINDOW`-th `cycle_start` after the previous window closed, counting only strobes after the first, the four totals appear on the outputs in the next cycle. In that same cycle `win_valid` is high for one cycle, and accumulation restarts from zero.
- R8: Each accumulator saturates at 2^CNT_W-1 and never wraps.
- R9: `wr_valid` and `rd_ready` are low before the first `cycle_start` and in every cycle where `cycle_start` is high; otherwise they are high.
- R10: The window outputs change only in the cycle after a closing `cycle_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | Erase/loop start strobe, loads seed |
| cycle_seed | input | 31 | Pattern seed for the loop |
| page_start | input | 1 | Read-back page boundary strobe |
| wr_valid | output | 1 | Pattern byte available |
| wr_ready | input | 1 | Rig accepts pattern byte |
| wr_data | output | DATA_W | Pattern byte |
| rd_valid | input | 1 | Read-back byte present |
| rd_ready | output | 1 | Block accepts read-back byte |
| rd_data | input | DATA_W | Read-back byte |
| win_valid | output | 1 | One-cycle window-complete pulse |
| win_plus_odd | output | CNT_W | Plus errors, odd pages |
| win_plus_even | output | CNT_W | Plus errors, even pages |
| win_minus_odd | output | CNT_W | Minus errors, odd pages |
| win_minus_even | output | CNT_W | Minus errors, even pages |

## Verification
The bench randomly stalls the write port and inserts idle read beats carrying junk data. A design whose generator advanced on stalls or idle beats would fall out of step, and nearly every later byte would count as an error. A zero seed is driven to expose a generator locked at all zeros. Plus-only flips on odd pages and minus-only flips on even pages expose swapped directions or swapped parity. One window of fully inverted bytes with narrow counters checks that saturation holds at the maximum instead of wrapping to small values. Windows are checked back to back, so totals that were not cleared would carry into the next window.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam int LFSR_W = 31;
  localparam int TAP_HI = 30;
  localparam int TAP_LO = 27;
  localparam int NUM_CNT = 4;  // index = {odd, minus}

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction
endpackage

// File: rtl/fec_lfsr.sv
module fec_lfsr
  import fec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              adv,
  output logic [DATA_W-1:0] data
);
  logic [LFSR_W-1:0] state_q, state_nx;

  always_comb begin
    state_nx = state_q;
    data     = '0;
    for (int i = 0; i < DATA_W; i++) begin
      state_nx = lfsr_step(state_nx);
      data[i]  = state_nx[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= LFSR_W'(1);
    else if (load) state_q <= (seed == '0) ? LFSR_W'(1) : seed;
    else if (adv)  state_q <= state_nx;
  end

  // R3: the sequence moves only on load or on an accepted beat
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(state_q));
endmodule

// File: rtl/fec_cmp.sv
module fec_cmp #(
  parameter int DATA_W = 8,
  localparam int INC_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] expect_bits,
  input  logic [DATA_W-1:0] got_bits,
  output logic [INC_W-1:0]  plus_n,
  output logic [INC_W-1:0]  minus_n
);
  logic [DATA_W-1:0] up_v, dn_v;
  assign up_v = ~expect_bits & got_bits;
  assign dn_v = expect_bits & ~got_bits;

  always_comb begin
    plus_n  = '0;
    minus_n = '0;
    for (int i = 0; i < DATA_W; i++) begin
      plus_n  = plus_n + INC_W'(up_v[i]);
      minus_n = minus_n + INC_W'(dn_v[i]);
    end
  end
endmodule

// File: rtl/fec_accum.sv
module fec_accum #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] acc
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, acc} + (CNT_W + 1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (add)      acc <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  // R8: no wrap while accumulating, and full scale is sticky
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> acc >= $past(acc));
  a_r8_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && acc == '1) |=> acc == '1);
endmodule

// File: rtl/flash_endurance_checker.sv
module flash_endurance_checker
  import fec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32,
  parameter int WINDOW = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic [30:0]       cycle_seed,
  input  logic              page_start,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              win_valid,
  output logic [CNT_W-1:0]  win_plus_odd,
  output logic [CNT_W-1:0]  win_plus_even,
  output logic [CNT_W-1:0]  win_minus_odd,
  output logic [CNT_W-1:0]  win_minus_even
);
  localparam int INC_W = $clog2(DATA_W + 1);
  localparam int CYC_W = $clog2(WINDOW + 1);

  logic             armed_q, odd_q;
  logic [CYC_W-1:0] cyc_q;
  logic             wr_fire, rd_fire, win_close;
  logic [DATA_W-1:0] rd_expect;
  logic [INC_W-1:0]  plus_n, minus_n;
  logic [CNT_W-1:0]  acc   [NUM_CNT];
  logic [CNT_W-1:0]  snap_q[NUM_CNT];

  assign wr_valid  = armed_q & ~cycle_start;
  assign rd_ready  = armed_q & ~cycle_start;
  assign wr_fire   = wr_valid & wr_ready;
  assign rd_fire   = rd_valid & rd_ready;
  assign win_close = cycle_start & armed_q & (cyc_q == CYC_W'(WINDOW - 1));

  fec_lfsr #(.DATA_W(DATA_W)) u_wr_gen (
    .clk(clk), .rst_n(rst_n), .load(cycle_start), .seed(cycle_seed),
    .adv(wr_fire), .data(wr_data));

  fec_lfsr #(.DATA_W(DATA_W)) u_rd_gen (
    .clk(clk), .rst_n(rst_n), .load(cycle_start), .seed(cycle_seed),
    .adv(rd_fire), .data(rd_expect));

  fec_cmp #(.DATA_W(DATA_W)) u_cmp (
    .expect_bits(rd_expect), .got_bits(rd_data),
    .plus_n(plus_n), .minus_n(minus_n));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    fec_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(win_close),
      .add(rd_fire && (odd_q == g[1])),
      .inc(g[0] ? minus_n : plus_n),
      .acc(acc[g]));

    always_ff @(posedge clk) begin
      if (!rst_n)         snap_q[g] <= '0;
      else if (win_close) snap_q[g] <= acc[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      odd_q     <= 1'b0;
      cyc_q     <= '0;
      win_valid <= 1'b0;
    end else begin
      win_valid <= win_close;
      if (cycle_start) begin
        armed_q <= 1'b1;
        odd_q   <= 1'b0;
        if (win_close)    cyc_q <= '0;
        else if (armed_q) cyc_q <= cyc_q + 1'b1;
      end else if (page_start) begin
        odd_q <= ~odd_q;
      end
    end
  end

  assign win_plus_even  = snap_q[0];
  assign win_minus_even = snap_q[1];
  assign win_plus_odd   = snap_q[2];
  assign win_minus_odd  = snap_q[3];

  // R2: an offered but refused pattern byte is held
  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_data));
  // R7: the window pulse always follows a start strobe
  a_r7_pulse_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(cycle_start));
  // R10: reported totals move only after a start strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> ($stable(win_plus_odd) && $stable(win_plus_even) &&
                      $stable(win_minus_odd) && $stable(win_minus_even)));
  // R9: no handshake can complete before the first start strobe
  a_r9_idle_before_arm: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (!wr_fire && !rd_fire));
endmodule

// File: tb/flash_endurance_checker_tb.sv
module flash_endurance_checker_tb;
  localparam int W   = 3;
  localparam int CW  = 7;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic cycle_start = 0, page_start = 0;
  logic [30:0] cycle_seed = '0;
  logic wr_valid, wr_ready = 0, rd_valid = 0, rd_ready, win_valid;
  logic [7:0] wr_data, rd_data = '0;
  logic [CW-1:0] w_po, w_pe, w_mo, w_me;

  int checks = 0, fails = 0;
  int refc[4];           // index {odd, minus}
  int snap[4];
  logic [30:0] wr_st, rd_st;
  bit armed = 0, odd = 0;
  int ncyc = 0;

  always #2 clk = ~clk;

  flash_endurance_checker #(.DATA_W(8), .CNT_W(CW), .WINDOW(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .cycle_seed(cycle_seed),
    .page_start(page_start), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .win_valid(win_valid), .win_plus_odd(w_po), .win_plus_even(w_pe),
    .win_minus_odd(w_mo), .win_minus_even(w_me));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [38:0] gen8(input logic [30:0] s);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      s    = {s[29:0], s[30] ^ s[27]};
      d[i] = s[0];
    end
    return {s, d};
  endfunction

  function automatic int pop8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  function automatic int sat(input int v);
    return (v > MAX) ? MAX : v;
  endfunction

  task automatic check_window_outputs(input string req);
    chk(w_pe == snap[0], {req, " plus even"},  w_pe, snap[0]);
    chk(w_me == snap[1], {req, " minus even"}, w_me, snap[1]);
    chk(w_po == snap[2], {req, " plus odd"},   w_po, snap[2]);
    chk(w_mo == snap[3], {req, " minus odd"},  w_mo, snap[3]);
  endtask

  task automatic start_cycle(input logic [30:0] seed);
    bit close = 0;
    @(negedge clk);
    cycle_start = 1; cycle_seed = seed;
    #1;
    chk(!wr_valid && !rd_ready, "R9 ready low at start", {wr_valid, rd_ready}, 0);
    if (armed) begin
      ncyc++;
      if (ncyc == W) begin
        close = 1; ncyc = 0;
        for (int k = 0; k < 4; k++) begin snap[k] = refc[k]; refc[k] = 0; end
      end
    end
    armed = 1; odd = 0;
    wr_st = (seed == 0) ? 31'd1 : seed;
    rd_st = wr_st;
    @(negedge clk);
    cycle_start = 0;
    chk(win_valid == close, "R7 window pulse", win_valid, close);
    if (close) begin
      check_window_outputs("R7");
      @(negedge clk);
      chk(win_valid == 0, "R7 pulse one cycle", win_valid, 0);
      repeat (3) @(negedge clk);
      check_window_outputs("R10 hold");
    end
  endtask

  task automatic write_beats(input int n);
    int done = 0;
    logic [38:0] g;
    while (done < n) begin
      @(negedge clk);
      wr_ready = ($urandom % 3) != 0;
      if (wr_ready) begin
        g = gen8(wr_st);
        chk(wr_valid && wr_data == g[7:0], "R2 pattern byte", wr_data, g[7:0]);
        wr_st = g[38:8];
        done++;
      end
    end
    @(negedge clk);
    wr_ready = 0;
  endtask

  task automatic new_page();
    @(negedge clk); page_start = 1;
    @(negedge clk); page_start = 0;
    odd = !odd;
  endtask

  // mode: 0 sparse random, 1 plus only, 2 minus only, 3 all inverted, 4 clean
  task automatic read_beats(input int n, input int mode);
    int done = 0;
    logic [38:0] g;
    logic [7:0] e, m, d;
    while (done < n) begin
      @(negedge clk);
      if (($urandom % 4) != 0) begin
        g = gen8(rd_st); e = g[7:0]; rd_st = g[38:8];
        m = $urandom;
        case (mode)
          0: m = m & 8'($urandom) & 8'($urandom);
          1: m = m & ~e;
          2: m = m & e;
          3: m = 8'hFF;
          default: m = 8'h00;
        endcase
        d = e ^ m;
        rd_data = d; rd_valid = 1;
        refc[{odd, 1'b0}] = sat(refc[{odd, 1'b0}] + pop8(~e & d));  // R4
        refc[{odd, 1'b1}] = sat(refc[{odd, 1'b1}] + pop8(e & ~d));  // R5
        done++;
      end else begin
        rd_valid = 0; rd_data = $urandom;  // R3 ignored junk
      end
    end
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic run_cycle(input logic [30:0] seed, input int pages, input int beats,
                           input int m_odd, input int m_even);
    start_cycle(seed);
    write_beats(pages * beats);
    for (int p = 0; p < pages; p++) begin
      new_page();
      read_beats(beats, odd ? m_odd : m_even);  // R6 parity
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 4; k++) begin refc[k] = 0; snap[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!win_valid && !wr_valid && !rd_ready, "R1 reset controls", {win_valid, wr_valid, rd_ready}, 0);
    check_window_outputs("R1 reset counts");

    // window 1: zero seed, random, then directed directions per parity
    run_cycle(31'd0, 2, 8, 0, 0);
    run_cycle(31'($urandom), 3, 6, 0, 0);
    run_cycle(31'h5A5A_5A5, 2, 10, 1, 2);
    // window 2: clean reads; totals must start from zero
    run_cycle(31'($urandom), 2, 6, 4, 4);
    run_cycle(31'($urandom), 2, 6, 4, 4);
    run_cycle(31'($urandom), 4, 5, 2, 1);
    // window 3: saturation on odd pages
    run_cycle(31'($urandom), 1, 40, 3, 3);
    run_cycle(31'($urandom), 2, 8, 3, 0);
    run_cycle(31'($urandom), 2, 6, 0, 0);
    start_cycle(31'($urandom));
    chk(w_po == MAX && w_mo == MAX, "R8 saturated", w_po, MAX);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule